// File: doc/BRIEF.md
# Transmit Queue with Drain Interrupt

This block holds the bytes a CPU queues for transmission in a small first-in first-out store. It hands them one at a time to a transmit shift register, and it decides when to tell the interrupt controller that the queue wants more data. Each write from the CPU adds one byte at the tail. Whenever the shift register reports that it is idle and a byte is waiting, the oldest byte moves out of the head slot and goes into the shift register in that same clock.

A mode input sets when the pending flag is raised. In slot mode it is raised every time a byte leaves the head slot. In drain mode it is raised only when the byte that leaves is the last one, so the queue is left empty. An event can only come from a byte moving into the shift register, so a queue that was never written never interrupts. The pending flag is raised only while the transmit interrupt enable is high. It stays set until the CPU writes another byte or issues a reset-pending command. The serializer itself lies outside the block and is seen only through a busy input and a load strobe.

Top module: `tx_drain_irq`

## Requirements
- R1: After a synchronous reset the queue is empty, and `irq_pend`, `sr_load` and `overrun` are all 0.
- R2: Bytes written with `wr_en` come out on `sr_data` in write order. The queue holds up to DEPTH (default 4) bytes.
- R3: A byte is handed over only in a cycle where `sr_busy` is 0 and the queue holds at least one byte. The handover removes exactly one byte. `sr_load` is a one-cycle pulse, and `sr_data` is valid in the cycle after the edge at which the byte was taken.
- R4: A write to a full queue in a cycle with no handover is dropped, and `overrun` pulses for one cycle. A write to a full queue in a cycle that also hands a byte over is accepted.
- R5: With `irq_mode` = 0 (slot mode), every handover raises `irq_pend`.
- R6: With `irq_mode` = 1 (drain mode), only a handover that leaves the queue empty raises `irq_pend`. A write in the same cycle keeps the queue from being empty, so that handover raises nothing.
- R7: A handover in a cycle where `tx_ie` is 0 never raises `irq_pend`.
- R8: A queue that holds no bytes never raises `irq_pend`, whatever the states of `sr_busy`, `tx_ie` and `irq_mode`.
- R9: `irq_pend` is sticky. It is cleared by any `wr_en` pulse, including a dropped write, or by `pend_clr`. If a raise and a clear fall in the same cycle, the raise wins.
- R10: `irq_pend` rises at the same clock edge at which `sr_load` pulses for the byte that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for one byte |
| wr_data | input | 8 | Byte written by the CPU |
| irq_mode | input | 1 | 0: raise on every head-slot release; 1: raise only on drain to empty |
| tx_ie | input | 1 | Transmit interrupt enable |
| pend_clr | input | 1 | Reset-pending command |
| sr_busy | input | 1 | Shift register is still sending a character |
| sr_load | output | 1 | One-cycle strobe: shift register takes `sr_data` |
| sr_data | output | 8 | Byte handed to the shift register |
| irq_pend | output | 1 | Sticky transmit-empty pending flag |
| overrun | output | 1 | One-cycle pulse for a dropped write |

## Verification
The CPU write and the handover to the shift register can fall in the same clock, and that collision matters in three ways. The write clears the pending flag while the handover may raise it. In drain mode the write keeps the queue from emptying. When the queue is full, the handover frees the slot the write needs. Random phases raise both the write rate and the idle rate of the shift register so that these cycles occur often, and directed cases force each of them. A bench model recomputes the head byte, the queue occupancy and the expected flag value every cycle and compares them with the outputs after each edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {
    IRQ_ON_SLOT  = 1'b0,
    IRQ_ON_DRAIN = 1'b1
  } irq_mode_e;

  typedef struct packed {
    logic pop;
    logic drained;
  } txq_evt_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_q,
  output logic          empty,
  output logic          drained,
  output logic          ovf_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          full, take, do_pop;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign do_pop = pop && !empty;
  assign take   = push && (!full || do_pop);

  always_comb begin
    cnt_nx = cnt;
    if (take && !do_pop)      cnt_nx = cnt + 1'b1;
    else if (!take && do_pop) cnt_nx = cnt - 1'b1;
  end

  assign drained = do_pop && (cnt_nx == '0);

  // storage without reset so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= push_data;
    if (do_pop) head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      ovf_q <= push && !take;
      if (take)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_drop_only_full_R4: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $past(full));
  assert_full_pop_accepts_R4: assert property (@(posedge clk) disable iff (rst)
    (full && push && do_pop) |=> full);
endmodule

// File: rtl/txq_loader.sv
module txq_loader (
  input  logic clk,
  input  logic rst,
  input  logic sr_busy,
  input  logic q_empty,
  output logic pop,
  output logic load_q
);
  assign pop = !sr_busy && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= pop;
  end

  assert_load_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(!sr_busy));
endmodule

// File: rtl/txq_irq.sv
module txq_irq
  import txq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  txq_evt_t  evt,
  input  irq_mode_e mode,
  input  logic      ie,
  input  logic      clr,
  output logic      pend_q
);
  logic hit;

  always_comb begin
    case (mode)
      IRQ_ON_DRAIN: hit = evt.drained;
      default:      hit = evt.pop;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (ie && hit) pend_q <= 1'b1;
    else if (clr)       pend_q <= 1'b0;
  end

  assert_raise_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(ie));
  assert_clear_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(clr));
endmodule

// File: rtl/tx_drain_irq.sv
module tx_drain_irq
  import txq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_mode,
  input  logic          tx_ie,
  input  logic          pend_clr,
  input  logic          sr_busy,
  output logic          sr_load,
  output logic [DW-1:0] sr_data,
  output logic          irq_pend,
  output logic          overrun
);
  logic     q_empty, q_drained, pop;
  txq_evt_t evt;

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(wr_en), .push_data(wr_data), .pop(pop),
    .head_q(sr_data), .empty(q_empty), .drained(q_drained), .ovf_q(overrun)
  );

  txq_loader u_loader (
    .clk(clk), .rst(rst), .sr_busy(sr_busy), .q_empty(q_empty),
    .pop(pop), .load_q(sr_load)
  );

  assign evt.pop     = pop;
  assign evt.drained = q_drained;

  txq_irq u_irq (
    .clk(clk), .rst(rst), .evt(evt), .mode(irq_mode_e'(irq_mode)),
    .ie(tx_ie), .clr(wr_en || pend_clr), .pend_q(irq_pend)
  );

  assert_raise_with_load_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend) |-> sr_load);
  assert_drain_mode_empty_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_pend) && $past(irq_mode)) |-> q_empty);
  assert_load_single_R3: assert property (@(posedge clk) disable iff (rst)
    sr_load |-> $past(!q_empty));
endmodule

// File: tb/tx_drain_irq_test.sv
module tx_drain_irq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, irq_mode = 1'b0, tx_ie = 1'b0, pend_clr = 1'b0, sr_busy = 1'b1;
  logic [7:0] wr_data = '0;
  logic sr_load, irq_pend, overrun;
  logic [7:0] sr_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mq[$];
  logic e_pend = 1'b0;

  always #2 clk = ~clk;

  tx_drain_irq uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .irq_mode(irq_mode),
    .tx_ie(tx_ie), .pend_clr(pend_clr), .sr_busy(sr_busy), .sr_load(sr_load),
    .sr_data(sr_data), .irq_pend(irq_pend), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic raise_of(input logic pop, input logic drained,
                                    input logic md, input logic ie);
    return ie && pop && (md ? drained : 1'b1);
  endfunction

  // one clock: drive at the falling edge, compare after the rising edge
  task automatic step(input logic w, input logic [7:0] d, input logic busy,
                      input logic ie, input logic md, input logic rp,
                      input string tag);
    logic pop, drop, drained, set;
    logic [7:0] head;
    wr_en = w; wr_data = d; sr_busy = busy; tx_ie = ie; irq_mode = md; pend_clr = rp;
    pop  = !busy && (mq.size() != 0);
    drop = w && (mq.size() == 4) && !pop;
    head = pop ? mq[0] : 8'h00;
    if (pop) void'(mq.pop_front());
    if (w && !drop) mq.push_back(d);
    drained = pop && (mq.size() == 0);
    set = raise_of(pop, drained, md, ie);
    e_pend = set | (e_pend & !(w | rp));
    @(posedge clk); #1;
    chk({tag, " R3 load"}, {7'd0, sr_load}, {7'd0, pop});
    if (pop) chk({tag, " R2 data"}, sr_data, head);
    chk({tag, " R4 overrun"}, {7'd0, overrun}, {7'd0, drop});
    chk({tag, " R9 pend"}, {7'd0, irq_pend}, {7'd0, e_pend});
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 load", {7'd0, sr_load}, 8'd0);
    chk("R1 pend", {7'd0, irq_pend}, 8'd0);
    chk("R1 overrun", {7'd0, overrun}, 8'd0);
    // R8 never-written queue stays quiet in both modes
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 1'b0, 1'b1, i[0], 1'b0, "R8 idle");
    chk("R8 pend idle", {7'd0, irq_pend}, 8'd0);
    // R4 fill while busy, then overflow
    for (int i = 0; i < 5; i++) step(1'b1, 8'h10 + 8'(i), 1'b1, 1'b1, 1'b1, 1'b0, "R4 fill");
    // R4 write into full queue together with a handover
    step(1'b1, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, "R4 full+pop");
    // R6 drain mode: the last byte raises pending
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R6 drain");
    chk("R6 pend after drain", {7'd0, irq_pend}, 8'd1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R9 clear cmd");
    // R5 slot mode: every load raises; R9 write+pop same cycle, raise wins
    step(1'b1, 8'h31, 1'b1, 1'b1, 1'b0, 1'b0, "R5 w1");
    step(1'b1, 8'h32, 1'b0, 1'b1, 1'b0, 1'b0, "R9 w+pop");
    chk("R5 pend slot", {7'd0, irq_pend}, 8'd1);
    // R6 write during last pop in drain mode: no raise
    step(1'b1, 8'h33, 1'b1, 1'b1, 1'b1, 1'b1, "R6 prep");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R6 pop");
    step(1'b1, 8'h34, 1'b0, 1'b1, 1'b1, 1'b0, "R6 w+last pop");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R7 pop ie0");
    chk("R7 pend ie0", {7'd0, irq_pend}, 8'd0);
    // R10 / random phases
    for (int ph = 0; ph < 40; ph++) begin
      int wp = 10 + int'($urandom % 80);
      int bp = int'($urandom % 90);
      logic md = 1'($urandom);
      for (int i = 0; i < 300; i++)
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < bp,
             ($urandom % 10) != 0, md, ($urandom % 20) == 0, "R10 rand");
    end
    // R1 reset again with bytes queued
    step(1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0, "R1 pre");
    rst = 1'b1; @(posedge clk); #1; @(negedge clk); rst = 1'b0;
    mq.delete(); e_pend = 1'b0;
    chk("R1 pend after rst", {7'd0, irq_pend}, 8'd0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R1 empty");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule